// File: doc/BRIEF.md
# LRU Stream-to-Line Allocator

A content-inspection engine can keep the partial state of a small, fixed number of traffic flows in its own storage lines. This block decides which line each packet works on. At the start of every packet the upstream logic presents the packet's flow ID. One cycle later the allocator answers with a line index. It also says whether the flow was already resident on that line. If it was not, it says whether a resident flow had to be pushed out to make room, and which flow that was.

Each line holds a busy flag, the ID of the flow that owns it and an age counter. The age counter measures how many packet starts have gone by since the line was last used. A miss prefers any free line. Only when every line is busy does the block evict, and it picks the line that has gone unused longest. A separate end-of-stream input frees a line so that it can be reused. The actual transfer of flow state to and from external memory is left to the surrounding logic, which acts on the eviction report.

Top module: `stream_line_alloc`

## Requirements
- R1: After reset every line is free and `rsp_valid` is 0, so the first request after reset is answered with line 0, `rsp_hit`=0 and `rsp_evict`=0.
- R2: `rsp_valid` is 1 in the cycle after each cycle with `req_valid`=1, and 0 otherwise. It is a one-cycle pulse for each request.
- R3: When the requested flow ID is held by a busy line, the response gives that line with `rsp_hit`=1 and `rsp_evict`=0.
- R4: When the flow is not resident and at least one line is free, the response gives the lowest-numbered free line with `rsp_hit`=0 and `rsp_evict`=0. That line becomes busy and owns the flow.
- R5: When the flow is not resident and all lines are busy, the response gives the line with the largest age, `rsp_evict`=1 and `rsp_evict_flow` equal to the flow ID that line held. The line then owns the new flow.
- R6: Every request increments the age of every line, except the line chosen by the response, whose age becomes 0.
- R7: When several busy lines share the largest age, the lowest-numbered one is evicted.
- R8: A cycle with `end_valid`=1 frees line `end_line`. A later request for the flow it held is then a miss, and the freed line can be reassigned. Ending a line that is already free has no effect.
- R9: Age counters saturate at 2^AGE_W-1 and do not wrap.
- R10: When `end_valid` and `req_valid` are both 1 in the same cycle, the request sees the busy state from before the release. If both name the same line, that line stays busy with the requesting flow.
- R11: `end_valid` on its own produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Packet start for `req_flow` |
| req_flow | input | FLOW_W | Flow ID of the arriving packet |
| end_valid | input | 1 | Stream on `end_line` has finished |
| end_line | input | IDX_W | Line to release |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_line | output | IDX_W | Line assigned to the packet |
| rsp_hit | output | 1 | The flow was already resident |
| rsp_evict | output | 1 | A resident flow was displaced |
| rsp_evict_flow | output | FLOW_W | ID of the displaced flow (0 when none) |

## Verification
The hardest situation to reach from the ports is a tie for the oldest age, together with the saturation of the counters. Every request moves all counters together and resets only one of them, so the busy lines normally hold distinct ages. The bench fills all lines and then keeps hitting every line except lines 0 and 1 for more requests than the counter range. This drives both of those counters to the maximum. The request count is chosen so that a counter that wrapped would leave them younger than the lines still being hit. The next two misses must then evict line 0 and then line 1.

// File: rtl/alloc_pkg.sv
// Package: shared types for the stream-to-line allocator.
// Assumes nothing beyond standard SystemVerilog.
package alloc_pkg;

    // Outcome of one allocation decision.
    typedef enum logic [1:0] {
        DEC_HIT   = 2'd0,
        DEC_FILL  = 2'd1,
        DEC_EVICT = 2'd2
    } alloc_dec_e;

endpackage

// File: rtl/line_lookup.sv
// Module: line_lookup
// Compares the requested flow ID against the flow held by every line, in
// parallel. Produces a vector of busy lines that match and a vector of free
// lines. Assumes at most one busy line holds any given flow ID.
module line_lookup #(
    parameter int NUM_LINES = 16,
    parameter int FLOW_W    = 16
) (
    input  logic [NUM_LINES-1:0]             busy,
    input  logic [NUM_LINES-1:0][FLOW_W-1:0] line_flow,
    input  logic [FLOW_W-1:0]                req_flow,
    output logic [NUM_LINES-1:0]             match_vec,
    output logic [NUM_LINES-1:0]             free_vec
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        // Per-line match and free detection.
        always_comb begin
            match_vec[g] = busy[g] && (line_flow[g] == req_flow);
            free_vec[g]  = !busy[g];
        end
    end

endmodule

// File: rtl/lowest_pick.sv
// Module: lowest_pick
// Priority encoder that returns the lowest set index of a vector.
// Assumes the index output is ignored when found is 0.
module lowest_pick #(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] vec,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/oldest_pick.sv
// Module: oldest_pick
// Finds the line with the largest age. On a tie the lowest index wins.
// Assumes it is consulted only when every line is busy.
module oldest_pick #(
    parameter int NUM_LINES = 16,
    parameter int AGE_W     = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0][AGE_W-1:0] age,
    output logic [IDX_W-1:0]                idx
);

    logic [AGE_W-1:0] best;

    // Linear scan; a strictly greater age is needed to replace the current best.
    always_comb begin
        best = age[0];
        idx  = '0;
        for (int i = 1; i < NUM_LINES; i++) begin
            if (age[i] > best) begin
                best = age[i];
                idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/line_state.sv
// Module: line_state
// Holds the busy flag, the owning flow ID and the saturating age counter of
// every line. On an update all ages step up except the selected line, which
// is cleared and takes on the new flow. A release clears a busy flag unless
// the same line is being assigned in the same cycle.
module line_state #(
    parameter int NUM_LINES = 16,
    parameter int FLOW_W    = 16,
    parameter int AGE_W     = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             upd,
    input  logic [IDX_W-1:0]                 sel_line,
    input  logic [FLOW_W-1:0]                new_flow,
    input  logic                             rel,
    input  logic [IDX_W-1:0]                 rel_line,
    output logic [NUM_LINES-1:0]             busy,
    output logic [NUM_LINES-1:0][FLOW_W-1:0] line_flow,
    output logic [NUM_LINES-1:0][AGE_W-1:0]  age
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic chosen;
        logic released;

        // Decode whether this line is targeted this cycle.
        always_comb begin
            chosen   = upd && (sel_line == IDX_W'(g));
            released = rel && (rel_line == IDX_W'(g));
        end

        // Busy flag: assignment takes precedence over release.
        always_ff @(posedge clk) begin
            if (!rst_n)        busy[g] <= 1'b0;
            else if (chosen)   busy[g] <= 1'b1;
            else if (released) busy[g] <= 1'b0;
        end

        // Owning flow ID, written on assignment.
        always_ff @(posedge clk) begin
            if (!rst_n)      line_flow[g] <= '0;
            else if (chosen) line_flow[g] <= new_flow;
        end

        // Age counter: clear when chosen, else saturating increment per request.
        always_ff @(posedge clk) begin
            if (!rst_n)               age[g] <= '0;
            else if (chosen)          age[g] <= '0;
            else if (upd && age[g] != AGE_MAX) age[g] <= age[g] + 1'b1;
        end
    end

endmodule

// File: rtl/stream_line_alloc.sv
// Module: stream_line_alloc (top)
// Maps each packet start onto one of NUM_LINES engine lines. A resident flow
// reuses its line, a new flow takes the lowest free line, and otherwise the
// least recently used line is evicted and reported. Registered response one
// cycle after the request. Assumes upstream never presents a flow ID that
// two busy lines hold, which this block never creates itself.
module stream_line_alloc #(
    parameter int NUM_LINES = 16,
    parameter int FLOW_W    = 16,
    parameter int AGE_W     = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [FLOW_W-1:0] req_flow,
    input  logic              end_valid,
    input  logic [IDX_W-1:0]  end_line,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_line,
    output logic              rsp_hit,
    output logic              rsp_evict,
    output logic [FLOW_W-1:0] rsp_evict_flow
);

    import alloc_pkg::*;

    logic [NUM_LINES-1:0]             busy_q;
    logic [NUM_LINES-1:0][FLOW_W-1:0] flow_q;
    logic [NUM_LINES-1:0][AGE_W-1:0]  age_q;
    logic [NUM_LINES-1:0]             match_vec;
    logic [NUM_LINES-1:0]             free_vec;
    logic                             hit_found;
    logic                             free_found;
    logic [IDX_W-1:0]                 hit_idx;
    logic [IDX_W-1:0]                 free_idx;
    logic [IDX_W-1:0]                 old_idx;
    alloc_dec_e                       dec;
    logic [IDX_W-1:0]                 dec_line;

    line_lookup #(.NUM_LINES(NUM_LINES), .FLOW_W(FLOW_W)) lookup_i (
        .busy      (busy_q),
        .line_flow (flow_q),
        .req_flow  (req_flow),
        .match_vec (match_vec),
        .free_vec  (free_vec)
    );

    lowest_pick #(.NUM_LINES(NUM_LINES)) hit_pick_i (
        .vec   (match_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    lowest_pick #(.NUM_LINES(NUM_LINES)) free_pick_i (
        .vec   (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    oldest_pick #(.NUM_LINES(NUM_LINES), .AGE_W(AGE_W)) old_pick_i (
        .age (age_q),
        .idx (old_idx)
    );

    // Choose the outcome: hit first, then a free line, then eviction.
    always_comb begin
        if (hit_found) begin
            dec      = DEC_HIT;
            dec_line = hit_idx;
        end else if (free_found) begin
            dec      = DEC_FILL;
            dec_line = free_idx;
        end else begin
            dec      = DEC_EVICT;
            dec_line = old_idx;
        end
    end

    line_state #(.NUM_LINES(NUM_LINES), .FLOW_W(FLOW_W), .AGE_W(AGE_W)) state_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (req_valid),
        .sel_line  (dec_line),
        .new_flow  (req_flow),
        .rel       (end_valid),
        .rel_line  (end_line),
        .busy      (busy_q),
        .line_flow (flow_q),
        .age       (age_q)
    );

    // Response valid pulse, one per request.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Response payload, captured only when a request is decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_line       <= '0;
            rsp_hit        <= 1'b0;
            rsp_evict      <= 1'b0;
            rsp_evict_flow <= '0;
        end else if (req_valid) begin
            rsp_line       <= dec_line;
            rsp_hit        <= (dec == DEC_HIT);
            rsp_evict      <= (dec == DEC_EVICT);
            rsp_evict_flow <= (dec == DEC_EVICT) ? flow_q[old_idx] : '0;
        end
    end

endmodule

// File: rtl/stream_line_alloc_chk.sv
// Module: stream_line_alloc_chk
// Property checker for stream_line_alloc, attached with bind. Observes the
// ports and the line state registers of the top module.
module stream_line_alloc_chk #(
    parameter int NUM_LINES = 16,
    parameter int FLOW_W    = 16,
    parameter int AGE_W     = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic                             end_valid,
    input logic [IDX_W-1:0]                 end_line,
    input logic                             rsp_valid,
    input logic [IDX_W-1:0]                 rsp_line,
    input logic                             rsp_hit,
    input logic                             rsp_evict,
    input logic [NUM_LINES-1:0]             busy_q,
    input logic [NUM_LINES-1:0][AGE_W-1:0]  age_q
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    hit_never_evicts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_evict);

    // R4
    chosen_line_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy_q[rsp_line]);

    // R6
    chosen_age_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (age_q[rsp_line] == '0));

    // R8
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_valid && !req_valid) |=> !busy_q[$past(end_line)]);

endmodule

bind stream_line_alloc stream_line_alloc_chk #(
    .NUM_LINES (NUM_LINES),
    .FLOW_W    (FLOW_W),
    .AGE_W     (AGE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .end_valid (end_valid),
    .end_line  (end_line),
    .rsp_valid (rsp_valid),
    .rsp_line  (rsp_line),
    .rsp_hit   (rsp_hit),
    .rsp_evict (rsp_evict),
    .busy_q    (busy_q),
    .age_q     (age_q)
);

// File: tb/stream_line_alloc_tb_top.sv
// Directed bench for stream_line_alloc: one task per scenario.
module stream_line_alloc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 16;
    localparam int FW   = 16;
    localparam int AW   = 8;
    localparam int IW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [FW-1:0] req_flow = '0;
    logic          end_valid = 1'b0;
    logic [IW-1:0] end_line = '0;
    logic          rsp_valid;
    logic [IW-1:0] rsp_line;
    logic          rsp_hit;
    logic          rsp_evict;
    logic [FW-1:0] rsp_evict_flow;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_line_alloc #(.NUM_LINES(NL), .FLOW_W(FW), .AGE_W(AW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_flow       (req_flow),
        .end_valid      (end_valid),
        .end_line       (end_line),
        .rsp_valid      (rsp_valid),
        .rsp_line       (rsp_line),
        .rsp_hit        (rsp_hit),
        .rsp_evict      (rsp_evict),
        .rsp_evict_flow (rsp_evict_flow)
    );

    // Record one comparison.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply synchronous reset.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; end_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue a request (optionally with a release) and check the response.
    task automatic req_chk(input string req, input int flow, input int line,
                           input int hit, input int ev, input int evflow,
                           input bit with_end = 1'b0, input int eline = 0);
        @(negedge clk);
        req_valid = 1'b1; req_flow = FW'(flow);
        end_valid = with_end; end_line = IW'(eline);
        @(posedge clk); #1;
        req_valid = 1'b0; end_valid = 1'b0;
        check(req, "rsp_valid", int'(rsp_valid), 1);
        check(req, "rsp_line", int'(rsp_line), line);
        check(req, "rsp_hit", int'(rsp_hit), hit);
        check(req, "rsp_evict", int'(rsp_evict), ev);
        check(req, "rsp_evict_flow", int'(rsp_evict_flow), evflow);
    endtask

    // Issue a request without checking.
    task automatic req_fast(input int flow);
        @(negedge clk);
        req_valid = 1'b1; req_flow = FW'(flow);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Release a line alone; confirm no response appears.
    task automatic end_chk(input int line);
        @(negedge clk);
        end_valid = 1'b1; end_line = IW'(line);
        @(posedge clk); #1;
        end_valid = 1'b0;
        check("R11", "rsp_valid on release", int'(rsp_valid), 0);
    endtask

    // Fill all lines with flows base+i.
    task automatic fill_all(input int base);
        for (int i = 0; i < NL; i++) req_chk("R4", base + i, i, 0, 0, 0);
    endtask

    // Scenario: reset state and first allocation.
    task automatic t_reset();
        do_reset();
        @(posedge clk); #1;
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        req_chk("R1", 16'h50, 0, 0, 0, 0);
        @(posedge clk); #1;
        check("R2", "rsp_valid pulse ends", int'(rsp_valid), 0);
    endtask

    // Scenario: fill, hit, LRU eviction order.
    task automatic t_fill_evict();
        do_reset();
        fill_all(16'h100);
        req_chk("R3", 16'h105, 5, 1, 0, 0);
        // ages now 16-i, line 5 zero: line 0 oldest
        req_chk("R5", 16'h200, 0, 0, 1, 16'h100);
        // line 1 now oldest (16)
        req_chk("R6", 16'h201, 1, 0, 1, 16'h101);
        req_chk("R5", 16'h200, 0, 1, 0, 0);
        req_chk("R3", 16'h100, 2, 0, 1, 16'h102);
    endtask

    // Scenario: releases and reuse.
    task automatic t_release();
        do_reset();
        for (int i = 0; i < 4; i++) req_chk("R4", i, i, 0, 0, 0);
        end_chk(1);
        req_chk("R8", 16'h30, 1, 0, 0, 0);
        end_chk(9);
        req_chk("R8", 16'h31, 4, 0, 0, 0);
        end_chk(2);
        req_chk("R8", 2, 2, 0, 0, 0);
    endtask

    // Scenario: release and request in the same cycle.
    task automatic t_simul();
        do_reset();
        fill_all(16'h100);
        req_chk("R10", 16'h300, 0, 0, 1, 16'h100, 1'b1, 0);
        req_chk("R10", 16'h300, 0, 1, 0, 0, 1'b1, 3);
        req_chk("R10", 16'h301, 3, 0, 0, 0);
    endtask

    // Scenario: saturation of two idle lines and the tie between them.
    task automatic t_saturate();
        do_reset();
        fill_all(16'h400);
        for (int n = 0; n < 246; n++) req_fast(16'h402 + (n % 14));
        req_chk("R9", 16'h500, 0, 0, 1, 16'h400);
        req_chk("R7", 16'h501, 1, 0, 1, 16'h401);
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_evict();
        t_release();
        t_simul();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule